// File: doc/BRIEF.md
# Debug Snapshot Serialiser

This block hands a debug host a 64-bit picture of the core's state over one serial data line. The picture is built from live core signals: a status byte (run flag, two state machines, three condition flags), a spare byte, the 16-bit instruction under decode, and the program counter, result and two source operand bytes. The host controls it with two pins: an active-low write pin that selects the phase, and a serial clock. While the write pin is low the data line is quiet and released, so the line can share a wire with the host's data-in path.

When the write pin returns high, the top bit of the picture appears on the output without any serial clock activity. The host can poll that bit, the core's run flag, just by reading the line repeatedly. Each falling serial clock edge then moves the output to the next lower bit. After 64 edges the order wraps back to the top bit and starts again, using whatever values the core holds at that moment. Both host pins are sampled with the block's own system clock, so the block is fully synchronous. Each host edge takes effect on the system clock edge that first sees it.

Top module: `dbg_snap_ser`

## Requirements
- R1: While reset is held low at a clock edge, `ser_do_o` and `ser_oe_o` are 0 from the next edge on, and after reset the bit position is 63.
- R2: One clock after a clock edge that samples `wr_n_i` low, `ser_oe_o` and `ser_do_o` are both 0.
- R3: One clock after the edge that first samples `wr_n_i` high, `ser_oe_o` is 1 and `ser_do_o` carries snapshot bit 63, with no serial clock edge needed.
- R4: In the output phase, each falling edge of `ser_clk_i` (1 then 0 on consecutive clock samples) moves the output to the next lower snapshot bit, so bits leave from 63 down to 0.
- R5: The falling serial edge that follows bit 0 returns the output to bit 63, and the sequence repeats.
- R6: Snapshot layout, bit 63 down to bit 0: status byte [63:56], spare byte [55:48], instruction [47:32], PC [31:24], result [23:16], source B [15:8], source A [7:0].
- R7: Status byte, bit 7 down to 0: run flag, system state (2 bits; 0 RESET, 1 LOAD, 2 STOP, 3 STEP), instruction state (2 bits; 0 IDLE, 1 INST, 2 LDCX, 3 WRPC), Zero, Sign, Carry.
- R8: A high-to-low transition of `wr_n_i` returns the bit position to 63, and serial clock edges while `wr_n_i` is low have no effect on it.
- R9: The output reflects the current input values of the selected bit, not a copy taken when the phase began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Host serial clock |
| wr_n_i | input | 1 | Host phase pin, low = host writes, high = block outputs |
| run_i | input | 1 | Core run flag |
| sys_st_i | input | 2 | System state machine code |
| ins_st_i | input | 2 | Instruction state machine code |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_c_i | input | 1 | Carry flag |
| spare_i | input | 8 | Spare byte |
| instr_i | input | 16 | Instruction under decode |
| pc_i | input | 8 | Program counter |
| result_i | input | 8 | Result byte |
| src_b_i | input | 8 | Source operand B |
| src_a_i | input | 8 | Source operand A |
| ser_do_o | output | 1 | Serial data out |
| ser_oe_o | output | 1 | Output enable for a shared data pin |

## Verification
The hardest situations to reach are the wrap after the 64th bit combined with a field that changes mid-stream, and a write-pin restart partway through a word. The stimulus clocks out a full word, changes the run flag and a low byte while shifting, and checks that the second pass shows the new values. A separate sequence stops the host partway through a word, pulses the serial clock while the write pin is low, and checks that the next output phase still opens on bit 63. Polling is tested by changing the run flag with no serial clock activity and watching the line follow it.

// File: rtl/dbg_snap_pkg.sv
// Shared widths and encodings for the debug snapshot serialiser.
// Assumes a snapshot made of whole bytes.
package dbg_snap_pkg;
    localparam int SNAP_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(SNAP_W);
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int N_BYTES = SNAP_W / BYTE_W;

    typedef enum logic [1:0] {
        SYS_RESET = 2'd0,
        SYS_LOAD  = 2'd1,
        SYS_STOP  = 2'd2,
        SYS_STEP  = 2'd3
    } sys_state_e;

    typedef enum logic [1:0] {
        INS_IDLE = 2'd0,
        INS_INST = 2'd1,
        INS_LDCX = 2'd2,
        INS_WRPC = 2'd3
    } ins_state_e;

    typedef struct packed {
        logic       run;
        sys_state_e sys_st;
        ins_state_e ins_st;
        logic       zf;
        logic       sf;
        logic       cf;
    } status_t;
endpackage

// File: rtl/dbg_snap_pack.sv
// Assembles the live snapshot word from the core fields.
// Assumes every field is already stable in the system clock domain.
module dbg_snap_pack
    import dbg_snap_pkg::*;
#(
    parameter int W = SNAP_W
) (
    input  logic          run_i,
    input  logic [1:0]    sys_st_i,
    input  logic [1:0]    ins_st_i,
    input  logic          flag_z_i,
    input  logic          flag_s_i,
    input  logic          flag_c_i,
    input  logic [7:0]    spare_i,
    input  logic [15:0]   instr_i,
    input  logic [7:0]    pc_i,
    input  logic [7:0]    result_i,
    input  logic [7:0]    src_b_i,
    input  logic [7:0]    src_a_i,
    output logic [W-1:0]  word_o
);
    status_t stat;

    // Build the status byte from flags and state codes.
    always_comb begin
        stat.run    = run_i;
        stat.sys_st = sys_state_e'(sys_st_i);
        stat.ins_st = ins_state_e'(ins_st_i);
        stat.zf     = flag_z_i;
        stat.sf     = flag_s_i;
        stat.cf     = flag_c_i;
    end

    // Concatenate fields, most relevant byte on top.
    always_comb begin
        word_o = {stat, spare_i, instr_i, pc_i, result_i, src_b_i, src_a_i};
    end
endmodule

// File: rtl/dbg_snap_cnt.sv
// Bit position counter. Samples the host pins once per system clock,
// steps down on serial clock falls during the output phase, and
// reloads the top position on any phase change.
// Assumes host pins are already synchronised to clk.
module dbg_snap_cnt
    import dbg_snap_pkg::*;
#(
    parameter int W  = SNAP_W,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk_i,
    input  logic          wr_n_i,
    output logic          phase_o,
    output logic [CW-1:0] pos_o
);
    localparam logic [CW-1:0] TOP = CW'(W - 1);

    logic sclk_q;
    logic wr_q;
    logic step;
    logic wr_edge;

    // Detect serial falls inside the output phase and write pin changes.
    always_comb begin
        step    = wr_q & wr_n_i & sclk_q & ~ser_clk_i;
        wr_edge = wr_q ^ wr_n_i;
    end

    // Register the host pins for edge detection and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            sclk_q <= ser_clk_i;
            wr_q   <= wr_n_i;
        end
    end

    // Position counter: reload on phase change, wrap down on steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_o <= TOP;
        end else if (wr_edge) begin
            pos_o <= TOP;
        end else if (step) begin
            pos_o <= (pos_o == '0) ? TOP : pos_o - CW'(1);
        end
    end

    assign phase_o = wr_q;

    // R8: a low write pin always leaves the position at the top.
    assert_low_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_i |=> pos_o == TOP);
    // R5: bit 0 followed by a step wraps to the top.
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pos_o == '0) |=> pos_o == TOP);
    // R4: without a serial fall or phase change the position holds.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_edge) |=> $stable(pos_o));
endmodule

// File: rtl/dbg_snap_mux.sv
// Two-level selector: picks a byte with the upper position bits,
// then a bit within it with the lower ones.
// Assumes W is a whole number of bytes.
module dbg_snap_mux
    import dbg_snap_pkg::*;
#(
    parameter int W  = SNAP_W,
    localparam int CW = $clog2(W),
    localparam int NB = W / BYTE_W
) (
    input  logic [W-1:0]  word_i,
    input  logic [CW-1:0] sel_i,
    output logic          bit_o
);
    logic [BYTE_W-1:0] lane [NB];
    logic [BYTE_W-1:0] lane_sel;

    // Split the word into byte lanes.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane[b] = word_i[b*BYTE_W +: BYTE_W];
    end

    // Pick the lane, then the bit.
    always_comb begin
        lane_sel = lane[sel_i[CW-1:BIT_W]];
        bit_o    = lane_sel[sel_i[BIT_W-1:0]];
    end
endmodule

// File: rtl/dbg_snap_ser.sv
// Top of the debug snapshot serialiser. Drives the selected snapshot
// bit while the write pin is high and keeps the line low and released
// otherwise. Assumes host pins are synchronised to clk upstream.
module dbg_snap_ser
    import dbg_snap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk_i,
    input  logic        wr_n_i,
    input  logic        run_i,
    input  logic [1:0]  sys_st_i,
    input  logic [1:0]  ins_st_i,
    input  logic        flag_z_i,
    input  logic        flag_s_i,
    input  logic        flag_c_i,
    input  logic [7:0]  spare_i,
    input  logic [15:0] instr_i,
    input  logic [7:0]  pc_i,
    input  logic [7:0]  result_i,
    input  logic [7:0]  src_b_i,
    input  logic [7:0]  src_a_i,
    output logic        ser_do_o,
    output logic        ser_oe_o
);
    logic [SNAP_W-1:0] snap;
    logic [CNT_W-1:0]  pos;
    logic              phase;
    logic              sel_bit;

    dbg_snap_pack #(.W(SNAP_W)) pack_i (
        .run_i(run_i), .sys_st_i(sys_st_i), .ins_st_i(ins_st_i),
        .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_c_i(flag_c_i),
        .spare_i(spare_i), .instr_i(instr_i), .pc_i(pc_i),
        .result_i(result_i), .src_b_i(src_b_i), .src_a_i(src_a_i),
        .word_o(snap)
    );

    dbg_snap_cnt #(.W(SNAP_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .wr_n_i(wr_n_i),
        .phase_o(phase), .pos_o(pos)
    );

    dbg_snap_mux #(.W(SNAP_W)) mux_i (
        .word_i(snap), .sel_i(pos), .bit_o(sel_bit)
    );

    // Gate the line to zero outside the output phase.
    always_comb begin
        ser_oe_o = phase;
        ser_do_o = phase & sel_bit;
    end

    // R2: a low write pin sample silences the line on the next cycle.
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_i |=> (!ser_oe_o && !ser_do_o));
    // R3: the phase opens on the top bit.
    assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe_o) |-> ser_do_o == snap[SNAP_W-1]);
    // R7: the top bit is the run flag while the phase is open and untouched.
    assert_run_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe_o) |-> ser_do_o == run_i);
endmodule

// File: tb/dbg_snap_ser_tb_top.sv
module dbg_snap_ser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk_i = 1'b0;
    logic        wr_n_i = 1'b0;
    logic        run_i = 1'b0;
    logic [1:0]  sys_st_i = '0;
    logic [1:0]  ins_st_i = '0;
    logic        flag_z_i = 1'b0, flag_s_i = 1'b0, flag_c_i = 1'b0;
    logic [7:0]  spare_i = '0;
    logic [15:0] instr_i = '0;
    logic [7:0]  pc_i = '0, result_i = '0, src_b_i = '0, src_a_i = '0;
    logic        ser_do_o, ser_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dbg_snap_ser dut_i (.*);

    // Expected words (R6/R7 layout): status byte on top, then spare,
    // instruction, PC, result, source B, source A.
    localparam int NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        64'hA5_3C_1234_56_78_9A_BC,
        64'h00_00_0000_00_00_00_01,
        64'hFF_FF_FFFF_FF_FF_FF_FE,
        64'h5A_C3_8001_0F_F0_33_CC,
        64'h47_01_DEAD_BE_EF_80_7F
    };

    task automatic drive(input logic [63:0] w);
        // R7: status bits run, sys[1:0], ins[1:0], Z, S, C
        run_i    = w[63];
        sys_st_i = w[62:61];
        ins_st_i = w[60:59];
        flag_z_i = w[58];
        flag_s_i = w[57];
        flag_c_i = w[56];
        // R6 byte layout
        spare_i  = w[55:48];
        instr_i  = w[47:32];
        pc_i     = w[31:24];
        result_i = w[23:16];
        src_b_i  = w[15:8];
        src_a_i  = w[7:0];
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic open_phase();
        @(negedge clk) wr_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk) wr_n_i = 1'b1;
        @(negedge clk);   // phase visible one clock after the rise
    endtask

    task automatic sclk_fall();
        @(negedge clk) ser_clk_i = 1'b1;
        @(negedge clk) ser_clk_i = 1'b0;
        @(negedge clk);   // step applied at the posedge in between
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drive(VEC[0]);
        wr_n_i = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_oe_o, 1'b0, "R1 oe in reset");
        check(ser_do_o, 1'b0, "R1 do in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_oe_o, 1'b1, "R1 oe after reset");
        check(ser_do_o, VEC[0][63], "R1 starts at bit 63");

        // R4/R6/R7: walk the vector table, full word MSB first
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v]);
            open_phase();
            check(ser_oe_o, 1'b1, "R3 oe");
            check(ser_do_o, VEC[v][63], "R3 early top bit");
            for (int k = 62; k >= 0; k--) begin
                sclk_fall();
                check(ser_do_o, VEC[v][k], (k >= 56) ? "R7 status bit" : "R4 R6 bit order");
            end
        end

        // R5/R9: wrap and second pass with changed live values
        drive(VEC[0]);
        open_phase();
        for (int k = 62; k >= 0; k--) sclk_fall();
        check(ser_do_o, VEC[0][0], "R4 last bit");
        drive(VEC[3]);
        sclk_fall();
        check(ser_do_o, VEC[3][63], "R5 wrap to top");
        for (int k = 62; k >= 0; k--) begin
            sclk_fall();
            check(ser_do_o, VEC[3][k], "R9 live second pass");
        end

        // R3/R9: polling without serial clock
        drive(VEC[1]);
        open_phase();
        check(ser_do_o, 1'b0, "R3 poll low");
        @(negedge clk) run_i = 1'b1;
        #0.5;
        check(ser_do_o, 1'b1, "R9 poll follows run");

        // R2/R8: restart midway; serial edges while low ignored
        drive(VEC[2]);
        for (int k = 0; k < 10; k++) sclk_fall();
        @(negedge clk) wr_n_i = 1'b0;
        @(negedge clk);
        check(ser_oe_o, 1'b0, "R2 oe low");
        check(ser_do_o, 1'b0, "R2 do low");
        for (int k = 0; k < 5; k++) begin
            sclk_fall();
            check(ser_do_o, 1'b0, "R2 quiet while clocked");
        end
        @(negedge clk) wr_n_i = 1'b1;
        @(negedge clk);
        check(ser_do_o, VEC[2][63], "R8 restart at top");
        sclk_fall();
        check(ser_do_o, VEC[2][62], "R8 then bit 62");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule